// File: doc/BRIEF.md
# YCbCr 4:2:2 output formatter

The formatter receives three parallel 10-bit sample channels on every pixel clock: red, green and blue. On the YCbCr side these are read as Cr, Y and Cb. It also receives a horizontal sync marker and a format select. It then drives a fixed-latency output stream in one of two formats.

- **Full-rate (4:4:4) format:** all three channels pass through unchanged.
- **Half-chroma (4:2:2) format:**
  - One lane carries luma on every clock.
  - A second lane carries chroma that alternates between Cb and Cr. Both chroma values of each pair come from the even-indexed pixel of that pair.
  - The third lane is held at zero.

The chroma pairing is anchored to the sync leading edge. The pixel that arrives with the rising edge of `sync_in` is pixel 0, so the first chroma of every line is Cb. The sync output leads the data it marks by an even number of clocks, so a downstream consumer that counts pixel pairs from sync stays aligned. A format change is picked up only at a sync leading edge, so no line is ever partly reformatted.

The stream runs at one pixel per clock and has no valid or ready qualifiers. The formatter cannot stall, so a consumer must accept every output word. No back-pressure path exists.

Top module: `fmt422_formatter`

## Requirements
- R1: In 4:4:4 format the outputs carry `out_ch0` = green, `out_ch1` = blue and `out_ch2` = red of the same input pixel, unchanged.
- R2: In 4:2:2 format `out_ch0` carries the green (luma) sample of every pixel, one per clock.
- R3: In 4:2:2 format, for an even-indexed pixel `out_ch1` carries that pixel's blue (Cb) sample and `c_is_cr` is 0. For an odd-indexed pixel `out_ch1` carries the red (Cr) sample of the preceding even pixel and `c_is_cr` is 1.
- R4: The pixel present on the clock where `sync_in` rises (0 on the previous clock, 1 now) is index 0, whatever the previous index was. In 4:2:2 format its chroma is therefore Cb.
- R5: In 4:2:2 format `out_ch2` is 0.
- R6: The data outputs, `c_is_cr` and `fmt_422_out` appear DATA_LAT (default 8) clocks after the input pixel is sampled, in both formats.
- R7: `sync_out` equals `sync_in` delayed by DATA_LAT - 2*SYNC_LEAD clocks (default 6). It therefore leads its data by an even number of clocks.
- R8: `mode_sel_in` (1 = 4:2:2, 0 = 4:4:4) is sampled only on the clock where `sync_in` rises. The sampled format applies from that pixel onward, and `fmt_422_out` reports it. After reset the format is 4:4:4 until the first sync edge.
- R9: While `rst_n` is low, and for the first DATA_LAT clocks after it is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| r_in | input | SAMPLE_W | Red / Cr sample channel |
| g_in | input | SAMPLE_W | Green / Y sample channel |
| b_in | input | SAMPLE_W | Blue / Cb sample channel |
| sync_in | input | 1 | Horizontal sync marker, active high |
| mode_sel_in | input | 1 | Requested format, 1 = 4:2:2, 0 = 4:4:4 |
| out_ch0 | output | SAMPLE_W | Green (4:4:4) or luma (4:2:2) |
| out_ch1 | output | SAMPLE_W | Blue (4:4:4) or Cb/Cr chroma (4:2:2) |
| out_ch2 | output | SAMPLE_W | Red (4:4:4) or zero (4:2:2) |
| sync_out | output | 1 | Delayed sync, even lead over data |
| fmt_422_out | output | 1 | Format of the word on the data outputs |
| c_is_cr | output | 1 | High when out_ch1 carries Cr |

## Verification
Some properties are checked on every clock at the formatting stage:
- luma follows the green input;
- even chroma is the blue input of the previous clock;
- odd chroma is the red input from two clocks back;
- the first pixel after a sync rise is even;
- the format never changes without a sync rise;
- the spare lane is zero in 4:2:2.

Other properties can only be shown by the bench's scenarios:
- the full eight-clock data latency and the six-clock sync delay;
- the effect of a sync edge that lands on an odd pixel;
- a mode request raised before the first sync or in the middle of a line being ignored;
- the clean all-zero state after a mid-stream reset.

// File: rtl/fmt422_pkg.sv
package fmt422_pkg;

  typedef enum logic {
    FMT_444 = 1'b0,
    FMT_422 = 1'b1
  } fmt_mode_e;

endpackage

// File: rtl/fmt_line_ctrl.sv
module fmt_line_ctrl
  import fmt422_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync_in,
  input  logic      mode_sel_in,
  output logic      line_start,
  output logic      pix_odd,
  output fmt_mode_e mode_now
);

  logic      sync_q;
  logic      odd_q;
  fmt_mode_e mode_q;

  // Rising edge of the sync marker restarts pixel indexing and locks the format
  assign line_start = sync_in & ~sync_q;
  assign pix_odd    = line_start ? 1'b0 : ~odd_q;
  assign mode_now   = line_start ? fmt_mode_e'(mode_sel_in) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      odd_q  <= 1'b1;     // first pixel after reset is even
      mode_q <= FMT_444;
    end else begin
      sync_q <= sync_in;
      odd_q  <= pix_odd;
      mode_q <= mode_now;
    end
  end

endmodule

// File: rtl/fmt_pack.sv
module fmt_pack
  import fmt422_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  localparam int WORD_W  = 3 * SAMPLE_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] r_in,
  input  logic [SAMPLE_W-1:0] g_in,
  input  logic [SAMPLE_W-1:0] b_in,
  input  logic                pix_odd,
  input  fmt_mode_e           mode_now,
  output logic [WORD_W-1:0]   word_q
);

  logic [SAMPLE_W-1:0] cr_hold;
  logic [SAMPLE_W-1:0] lane0, lane1, lane2;

  always_comb begin
    lane0 = g_in;
    if (mode_now == FMT_422) begin
      lane1 = pix_odd ? cr_hold : b_in;
      lane2 = '0;
    end else begin
      lane1 = b_in;
      lane2 = r_in;
    end
  end

  // Word layout: {is_422, odd, lane2, lane1, lane0}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_hold <= '0;
      word_q  <= '0;
    end else begin
      if (!pix_odd) cr_hold <= r_in;
      word_q <= {mode_now == FMT_422, pix_odd, lane2, lane1, lane0};
    end
  end

endmodule

// File: rtl/fmt_pipe.sv
module fmt_pipe #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else begin : g_sr
      logic [W-1:0] sr [DEPTH];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/fmt422_formatter.sv
module fmt422_formatter
  import fmt422_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int DATA_LAT  = 8,
  parameter int SYNC_LEAD = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [SAMPLE_W-1:0] r_in,
  input  logic [SAMPLE_W-1:0] g_in,
  input  logic [SAMPLE_W-1:0] b_in,
  input  logic                sync_in,
  input  logic                mode_sel_in,
  output logic [SAMPLE_W-1:0] out_ch0,
  output logic [SAMPLE_W-1:0] out_ch1,
  output logic [SAMPLE_W-1:0] out_ch2,
  output logic                sync_out,
  output logic                fmt_422_out,
  output logic                c_is_cr
);

  localparam int WORD_W   = 3 * SAMPLE_W + 2;
  localparam int SYNC_LAT = DATA_LAT - 2 * SYNC_LEAD;

  logic              line_start;
  logic              pix_odd;
  fmt_mode_e         mode_now;
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] word_out;

  fmt_line_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .sync_in    (sync_in),
    .mode_sel_in(mode_sel_in),
    .line_start (line_start),
    .pix_odd    (pix_odd),
    .mode_now   (mode_now)
  );

  fmt_pack #(.SAMPLE_W(SAMPLE_W)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .r_in    (r_in),
    .g_in    (g_in),
    .b_in    (b_in),
    .pix_odd (pix_odd),
    .mode_now(mode_now),
    .word_q  (word_q)
  );

  // Packing stage is one register; the rest of the data latency follows
  fmt_pipe #(.W(WORD_W), .DEPTH(DATA_LAT - 1)) u_data_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (word_q),
    .q    (word_out)
  );

  fmt_pipe #(.W(1), .DEPTH(SYNC_LAT)) u_sync_dly (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (sync_in),
    .q    (sync_out)
  );

  assign out_ch0     = word_out[SAMPLE_W-1:0];
  assign out_ch1     = word_out[2*SAMPLE_W-1:SAMPLE_W];
  assign out_ch2     = word_out[3*SAMPLE_W-1:2*SAMPLE_W];
  assign fmt_422_out = word_out[WORD_W-1];
  assign c_is_cr     = word_out[WORD_W-1] & word_out[WORD_W-2];

  logic unused_line_start;
  assign unused_line_start = line_start;

endmodule

// File: rtl/fmt422_checker.sv
module fmt422_checker #(
  parameter int SAMPLE_W = 10,
  localparam int WORD_W  = 3 * SAMPLE_W + 2
) (
  input logic                clk,
  input logic                rst_n,
  input logic [SAMPLE_W-1:0] r_in,
  input logic [SAMPLE_W-1:0] g_in,
  input logic [SAMPLE_W-1:0] b_in,
  input logic                sync_in,
  input logic [WORD_W-1:0]   word_q,
  input logic                fmt_422_out,
  input logic [SAMPLE_W-1:0] out_ch2
);

  logic                q_422, q_odd;
  logic [SAMPLE_W-1:0] q_c0, q_c1, q_c2;

  assign q_422 = word_q[WORD_W-1];
  assign q_odd = word_q[WORD_W-2];
  assign q_c2  = word_q[3*SAMPLE_W-1:2*SAMPLE_W];
  assign q_c1  = word_q[2*SAMPLE_W-1:SAMPLE_W];
  assign q_c0  = word_q[SAMPLE_W-1:0];

  AST_PASS_444: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !q_422) |-> (q_c2 == $past(r_in) && q_c1 == $past(b_in) && q_c0 == $past(g_in))); // R1

  AST_LUMA_GREEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && q_422) |-> q_c0 == $past(g_in)); // R2

  AST_CB_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && q_422 && !q_odd) |-> q_c1 == $past(b_in)); // R3

  AST_CR_ODD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && q_422 && q_odd) |-> q_c1 == $past(r_in, 2)); // R3

  AST_FIRST_CB: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sync_in) && !$past(sync_in, 2)) |-> !q_odd); // R4

  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_422_out |-> out_ch2 == '0); // R5

  AST_MODE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2) && !($past(sync_in) && !$past(sync_in, 2)))
      |-> q_422 == $past(q_422)); // R8

endmodule

bind fmt422_formatter fmt422_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .r_in       (r_in),
  .g_in       (g_in),
  .b_in       (b_in),
  .sync_in    (sync_in),
  .word_q     (word_q),
  .fmt_422_out(fmt_422_out),
  .out_ch2    (out_ch2)
);

// File: tb/fmt422_formatter_test.sv
module fmt422_formatter_test;

  localparam int W     = 10;
  localparam int LAT   = 8;
  localparam int LEAD  = 1;
  localparam int SLAT  = LAT - 2 * LEAD;
  localparam int N     = 48;
  localparam int STEPS = N + LAT;

  // {sync_in, mode_sel_in} per clock
  localparam logic [1:0] VEC [0:N-1] = '{
    2'b00, 2'b00, 2'b01, 2'b01,                 // mode request before any sync: ignored
    2'b11, 2'b11, 2'b01, 2'b01, 2'b01,          // sync rise -> 4:2:2
    2'b00, 2'b00, 2'b01, 2'b01,                 // mid-line mode drop: ignored
    2'b11, 2'b11, 2'b01, 2'b01, 2'b01, 2'b01,   // sync on odd pixel: phase restart
    2'b01, 2'b01,
    2'b10, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,   // sync rise -> 4:4:4, requests ignored
    2'b11, 2'b01, 2'b11, 2'b01, 2'b01, 2'b01,   // two close sync rises
    2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01,
    2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
    2'b00, 2'b00, 2'b00
  };

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] r_in, g_in, b_in;
  logic         sync_in, mode_sel_in;
  logic [W-1:0] out_ch0, out_ch1, out_ch2;
  logic         sync_out, fmt_422_out, c_is_cr;

  always #4 clk = ~clk;

  fmt422_formatter #(.SAMPLE_W(W), .DATA_LAT(LAT), .SYNC_LEAD(LEAD)) uut (
    .clk(clk), .rst_n(rst_n), .r_in(r_in), .g_in(g_in), .b_in(b_in),
    .sync_in(sync_in), .mode_sel_in(mode_sel_in),
    .out_ch0(out_ch0), .out_ch1(out_ch1), .out_ch2(out_ch2),
    .sync_out(sync_out), .fmt_422_out(fmt_422_out), .c_is_cr(c_is_cr)
  );

  int checks = 0;
  int fails  = 0;

  int    e0 [STEPS], e1 [STEPS], e2 [STEPS], ecr [STEPS], e422 [STEPS];
  int    s_hist [STEPS];
  string etag [STEPS];

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int  pos;
    bit  prev_s, lm, ev, s, m;
    int  hold, rv, gv, bv;

    rst_n = 1'b0; r_in = '0; g_in = '0; b_in = '0; sync_in = 1'b0; mode_sel_in = 1'b0;
    pos = -1; prev_s = 1'b0; lm = 1'b0; hold = 0;
    repeat (3) @(negedge clk);
    chk("R9", "ch0 in reset", int'(out_ch0), 0);
    chk("R9", "sync_out in reset", int'(sync_out), 0);
    rst_n = 1'b1;

    for (int k = 0; k < STEPS; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        chk(etag[k-LAT], "ch0", int'(out_ch0), e0[k-LAT]);
        chk(etag[k-LAT], "ch1", int'(out_ch1), e1[k-LAT]);
        chk(e422[k-LAT] != 0 ? "R5" : "R1", "ch2", int'(out_ch2), e2[k-LAT]);
        chk("R3", "c_is_cr", int'(c_is_cr), ecr[k-LAT]);
        chk("R8", "fmt_422_out", int'(fmt_422_out), e422[k-LAT]);
      end else begin
        chk("R9", "ch0 after reset", int'(out_ch0), 0);
        chk("R9", "ch1 after reset", int'(out_ch1), 0);
        chk("R9", "fmt after reset", int'(fmt_422_out), 0);
      end
      if (k >= SLAT) chk("R7", "sync_out", int'(sync_out), s_hist[k-SLAT]);
      else           chk("R9", "sync_out after reset", int'(sync_out), 0);

      if (k < STEPS - LAT) begin
        s = VEC[k][1]; m = VEC[k][0];
        rv = (k * 3 + 'h100) & 'h3ff;
        gv = (k * 5 + 'h080) & 'h3ff;
        bv = (k * 11 + 'h2c0) & 'h3ff;
        r_in = W'(rv); g_in = W'(gv); b_in = W'(bv);
        sync_in = s; mode_sel_in = m;
        s_hist[k] = int'(s);
        if (s && !prev_s) begin pos = 0; lm = m; end
        else pos++;
        prev_s = s;
        ev = (pos % 2 == 0);
        if (ev) hold = rv;
        if (lm) begin
          e0[k] = gv; e1[k] = ev ? bv : hold; e2[k] = 0; ecr[k] = ev ? 0 : 1; e422[k] = 1;
          etag[k] = (pos == 0) ? "R4 R6" : "R2 R3 R6";
        end else begin
          e0[k] = gv; e1[k] = bv; e2[k] = rv; ecr[k] = 0; e422[k] = 0;
          etag[k] = "R1 R6";
        end
      end else begin
        sync_in = 1'b0; mode_sel_in = 1'b0;
      end
    end

    // Directed: mid-stream reset clears outputs at once (R9)
    r_in = 10'h155; g_in = 10'h2aa; b_in = 10'h0f0; sync_in = 1'b1; mode_sel_in = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9", "ch1 async reset", int'(out_ch1), 0);
    chk("R9", "sync_out async reset", int'(sync_out), 0);
    @(negedge clk);
    // After reset the format is 4:4:4 despite the request (R8), pass-through (R1)
    sync_in = 1'b0; mode_sel_in = 1'b1;
    rst_n = 1'b1;
    for (int k = 0; k < LAT; k++) @(negedge clk);
    chk("R8", "fmt after reset default", int'(fmt_422_out), 0);
    chk("R1", "ch2 red after reset", int'(out_ch2), 'h155);
    chk("R1", "ch1 blue after reset", int'(out_ch1), 'h0f0);
    chk("R6", "ch0 green after reset", int'(out_ch0), 'h2aa);

    summary();
  end

endmodule